// File: doc/BRIEF.md
# Two-by-two self-routing arbitrating switch cell

This cell is one switching element of a multistage processor-to-memory network. It has two upstream ports facing the processors and two downstream ports facing the memories or the next stage. Each upstream port offers a request flag, a single routing bit, an address, write data and a write-enable strobe. It receives read data and a busy flag in return. The routing bit names the downstream port the request must leave on. A 0 selects downstream port 0, the upper one. A 1 selects downstream port 1, the lower one. No global controller takes part: each cell decides from its own inputs.

When both upstream ports ask for the same downstream port, port 0 always wins. The losing port gets busy at once. The winning path also carries busy back from further down the network, so a source learns about a block anywhere along its route. The cell is purely combinational. A single cross/straight setting steers the forward bundle and the returning read data. The connection lasts as long as the request lines stay high.

Top module: `route_cell2x2`

## Requirements
- R1: With no request on either upstream port, both `dn_req_o` bits are 0 and both `busy_o` bits are 0, whatever `dn_busy_i` holds.
- R2: A lone request on upstream port i with routing bit d raises `dn_req_o[d]` only. d = 0 names downstream port 0 (upper) and d = 1 names downstream port 1 (lower). Bit k of every 2-bit vector belongs to port k.
- R3: Two requests with different routing bits are both forwarded: `dn_req_o` = 2'b11 and neither is blocked.
- R4: Two requests with equal routing bits forward only upstream port 0. `busy_o[1]` is then 1.
- R5: The address, write data and write-enable of each forwarded request appear on the downstream port its routing bit names.
- R6: The read data presented on a downstream port returns on `rdata_o` of the upstream port forwarded to it.
- R7: A downstream busy is passed to the upstream port forwarded to that downstream port, and only to that one.
- R8: An upstream port without a request never shows busy.
- R9: The connection follows the held request lines. While they stay constant, changes on downstream read data reach the connected upstream port with no re-request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_i | input | 2 | Request flag per upstream port |
| dir_i | input | 2 | Routing bit per upstream port (0 upper, 1 lower) |
| addr_i | input | 2*ADDR_W | Address per upstream port, port k in slice k |
| wdata_i | input | 2*DATA_W | Write data per upstream port |
| we_i | input | 2 | Write-enable per upstream port |
| rdata_o | output | 2*DATA_W | Read data returned to each upstream port |
| busy_o | output | 2 | Busy returned to each upstream port |
| dn_req_o | output | 2 | Request flag per downstream port |
| dn_addr_o | output | 2*ADDR_W | Address per downstream port |
| dn_wdata_o | output | 2*DATA_W | Write data per downstream port |
| dn_we_o | output | 2 | Write-enable per downstream port |
| dn_rdata_i | input | 2*DATA_W | Read data arriving on each downstream port |
| dn_busy_i | input | 2 | Busy arriving on each downstream port |

## Verification
The bench builds the cell with ADDR_W = 10 and DATA_W = 12, not with the defaults. A slicing mistake that happens to line up at the default widths would then misplace fields. Each port's address and data carry distinct patterns, so a swapped slice shows as a wrong value. The vector table covers all sixteen relevant request, routing-bit and downstream-busy mixes. These include busy arriving on a downstream port that no source is using.

// File: rtl/route2_pkg.sv
package route2_pkg;

  typedef enum logic {
    LINK_STRAIGHT = 1'b0,
    LINK_CROSS    = 1'b1
  } link_e;

  // Port 0 always granted when asking; port 1 loses on equal routing bits.
  function automatic logic [1:0] grant_of(input logic [1:0] req, input logic [1:0] dir);
    logic [1:0] g;
    g[0] = req[0];
    g[1] = req[1] & ~(req[0] & (dir[0] == dir[1]));
    return g;
  endfunction

  // Port 0 sets the link when active, otherwise port 1 does.
  function automatic link_e link_of(input logic [1:0] req, input logic [1:0] dir);
    logic x;
    if (req[0]) x = dir[0];
    else        x = req[1] & ~dir[1];
    return link_e'(x);
  endfunction

  // Upstream port feeding downstream port o (and vice versa) under a link setting.
  function automatic int unsigned peer_of(input int unsigned o, input link_e lk);
    return (lk == LINK_CROSS) ? (1 - o) : o;
  endfunction

endpackage

// File: rtl/route2_arbiter.sv
module route2_arbiter
  import route2_pkg::*;
(
  input  logic [1:0] req,
  input  logic [1:0] dir,
  output logic [1:0] grant,
  output logic [1:0] blocked,
  output link_e      link
);
  always_comb begin
    grant   = grant_of(req, dir);
    blocked = req & ~grant;
    link    = link_of(req, dir);
  end
endmodule

// File: rtl/route2_fwd_path.sv
module route2_fwd_path
  import route2_pkg::*;
#(
  parameter int unsigned BUS_W = 8
) (
  input  link_e              link,
  input  logic [1:0]         grant,
  input  logic [2*BUS_W-1:0] up_bus,
  output logic [1:0]         dn_req,
  output logic [2*BUS_W-1:0] dn_bus
);
  for (genvar o = 0; o < 2; o++) begin : g_out
    always_comb begin
      if (link == LINK_CROSS) begin
        dn_req[o]                 = grant[1-o];
        dn_bus[o*BUS_W +: BUS_W]  = up_bus[(1-o)*BUS_W +: BUS_W];
      end else begin
        dn_req[o]                 = grant[o];
        dn_bus[o*BUS_W +: BUS_W]  = up_bus[o*BUS_W +: BUS_W];
      end
    end
  end
endmodule

// File: rtl/route2_ret_path.sv
module route2_ret_path
  import route2_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  link_e               link,
  input  logic [1:0]          grant,
  input  logic [1:0]          blocked,
  input  logic [2*DATA_W-1:0] dn_rdata,
  input  logic [1:0]          dn_busy,
  output logic [2*DATA_W-1:0] up_rdata,
  output logic [1:0]          up_busy
);
  for (genvar i = 0; i < 2; i++) begin : g_up
    always_comb begin
      if (link == LINK_CROSS) begin
        up_rdata[i*DATA_W +: DATA_W] = dn_rdata[(1-i)*DATA_W +: DATA_W];
        up_busy[i] = blocked[i] | (grant[i] & dn_busy[1-i]);
      end else begin
        up_rdata[i*DATA_W +: DATA_W] = dn_rdata[i*DATA_W +: DATA_W];
        up_busy[i] = blocked[i] | (grant[i] & dn_busy[i]);
      end
    end
  end
endmodule

// File: rtl/route_cell2x2.sv
module route_cell2x2
  import route2_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic [1:0]          req_i,
  input  logic [1:0]          dir_i,
  input  logic [2*ADDR_W-1:0] addr_i,
  input  logic [2*DATA_W-1:0] wdata_i,
  input  logic [1:0]          we_i,
  output logic [2*DATA_W-1:0] rdata_o,
  output logic [1:0]          busy_o,
  output logic [1:0]          dn_req_o,
  output logic [2*ADDR_W-1:0] dn_addr_o,
  output logic [2*DATA_W-1:0] dn_wdata_o,
  output logic [1:0]          dn_we_o,
  input  logic [2*DATA_W-1:0] dn_rdata_i,
  input  logic [1:0]          dn_busy_i
);
  localparam int unsigned BUS_W = 1 + DATA_W + ADDR_W;

  logic [1:0]         grant;
  logic [1:0]         blocked;
  link_e              link;
  logic [2*BUS_W-1:0] up_bus;
  logic [2*BUS_W-1:0] dn_bus;

  route2_arbiter u_arb (
    .req     (req_i),
    .dir     (dir_i),
    .grant   (grant),
    .blocked (blocked),
    .link    (link)
  );

  for (genvar k = 0; k < 2; k++) begin : g_pack
    assign up_bus[k*BUS_W +: BUS_W] =
      {we_i[k], wdata_i[k*DATA_W +: DATA_W], addr_i[k*ADDR_W +: ADDR_W]};
    assign dn_addr_o[k*ADDR_W +: ADDR_W]  = dn_bus[k*BUS_W +: ADDR_W];
    assign dn_wdata_o[k*DATA_W +: DATA_W] = dn_bus[k*BUS_W + ADDR_W +: DATA_W];
    assign dn_we_o[k]                     = dn_bus[k*BUS_W + ADDR_W + DATA_W];
  end

  route2_fwd_path #(.BUS_W(BUS_W)) u_fwd (
    .link   (link),
    .grant  (grant),
    .up_bus (up_bus),
    .dn_req (dn_req_o),
    .dn_bus (dn_bus)
  );

  route2_ret_path #(.DATA_W(DATA_W)) u_ret (
    .link     (link),
    .grant    (grant),
    .blocked  (blocked),
    .dn_rdata (dn_rdata_i),
    .dn_busy  (dn_busy_i),
    .up_rdata (rdata_o),
    .up_busy  (busy_o)
  );
endmodule

// File: rtl/route_cell2x2_chk.sv
module route_cell2x2_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input logic [1:0]          req_i,
  input logic [1:0]          dir_i,
  input logic [2*ADDR_W-1:0] addr_i,
  input logic [2*DATA_W-1:0] wdata_i,
  input logic [1:0]          we_i,
  input logic [2*DATA_W-1:0] rdata_o,
  input logic [1:0]          busy_o,
  input logic [1:0]          dn_req_o,
  input logic [2*ADDR_W-1:0] dn_addr_o,
  input logic [2*DATA_W-1:0] dn_wdata_o,
  input logic [1:0]          dn_we_o,
  input logic [2*DATA_W-1:0] dn_rdata_i,
  input logic [1:0]          dn_busy_i
);
  logic same_target;
  assign same_target = req_i[0] & req_i[1] & (dir_i[0] == dir_i[1]);

  always_comb begin
    if (req_i == 2'b00)
      assert_idle_cell_R1: assert (dn_req_o == 2'b00 && busy_o == 2'b00);
    if (same_target)
      assert_loser_busy_R4: assert (busy_o[1] && $countones(dn_req_o) == 1);
    if (!same_target)
      assert_fanout_R3: assert ($countones(dn_req_o) == $countones(req_i));
    for (int i = 0; i < 2; i++) begin
      if (!req_i[i])
        assert_quiet_idle_R8: assert (!busy_o[i]);
      if (req_i[i] && !(i == 1 && same_target)) begin
        assert_routed_R2: assert (dn_req_o[dir_i[i]]);
        assert_addr_fwd_R5: assert (dn_addr_o[dir_i[i]*ADDR_W +: ADDR_W] == addr_i[i*ADDR_W +: ADDR_W]);
        assert_wdata_fwd_R5: assert (dn_wdata_o[dir_i[i]*DATA_W +: DATA_W] == wdata_i[i*DATA_W +: DATA_W]
                                     && dn_we_o[dir_i[i]] == we_i[i]);
        assert_rdata_ret_R6: assert (rdata_o[i*DATA_W +: DATA_W] == dn_rdata_i[dir_i[i]*DATA_W +: DATA_W]);
        assert_busy_relay_R7: assert (busy_o[i] == dn_busy_i[dir_i[i]]);
      end
    end
  end
endmodule

bind route_cell2x2 route_cell2x2_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .req_i      (req_i),
  .dir_i      (dir_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .we_i       (we_i),
  .rdata_o    (rdata_o),
  .busy_o     (busy_o),
  .dn_req_o   (dn_req_o),
  .dn_addr_o  (dn_addr_o),
  .dn_wdata_o (dn_wdata_o),
  .dn_we_o    (dn_we_o),
  .dn_rdata_i (dn_rdata_i),
  .dn_busy_i  (dn_busy_i)
);

// File: tb/route_cell2x2_bench.sv
module route_cell2x2_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 12;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]      req_i = '0, dir_i = '0, we_i = '0, dn_busy_i = '0;
  logic [2*AW-1:0] addr_i = '0;
  logic [2*DW-1:0] wdata_i = '0, dn_rdata_i = '0;
  logic [2*DW-1:0] rdata_o, dn_wdata_o;
  logic [2*AW-1:0] dn_addr_o;
  logic [1:0]      busy_o, dn_req_o, dn_we_o;

  route_cell2x2 #(.ADDR_W(AW), .DATA_W(DW)) u_route_cell2x2 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // {req[1:0], dir[1:0], dn_busy[1:0], exp dn_req[1:0], exp busy[1:0]}
  localparam logic [9:0] VEC [16] = '{
    10'b00_00_11_00_00, // R1 R8
    10'b01_00_00_01_00, // R2
    10'b01_01_00_10_00, // R2
    10'b10_00_00_01_00, // R2
    10'b10_10_00_10_00, // R2
    10'b11_10_00_11_00, // R3
    10'b11_01_00_11_00, // R3
    10'b11_00_00_01_10, // R4
    10'b11_11_00_10_10, // R4
    10'b11_00_01_01_11, // R4 R7
    10'b11_10_10_11_10, // R7
    10'b11_01_01_11_10, // R7
    10'b01_01_10_10_01, // R7
    10'b10_00_10_01_00, // R7
    10'b10_10_11_10_10, // R7
    10'b01_00_10_01_00  // R7 R8
  };

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset state: all inputs idle from time zero (R1)
    @(negedge clk); #1;
    check("R1 idle dn_req", 32'(dn_req_o), 32'h0);
    check("R1 idle busy",   32'(busy_o),   32'h0);

    for (int v = 0; v < 16; v++) begin
      logic [9:0] e;
      logic blk1;
      e = VEC[v];
      @(negedge clk);
      req_i = e[9:8]; dir_i = e[7:6]; dn_busy_i = e[5:4];
      addr_i     = {AW'(10'h2B0 + v), AW'(10'h150 + v)};
      wdata_i    = {DW'(12'hB00 + v), DW'(12'hA00 + v)};
      we_i       = 2'(v);
      dn_rdata_i = {DW'(12'hD10 + v), DW'(12'hC20 + v)};
      #1;
      check($sformatf("R2/R3/R4 vec%0d dn_req", v), 32'(dn_req_o), 32'(e[3:2]));
      check($sformatf("R4/R7/R8 vec%0d busy", v),   32'(busy_o),   32'(e[1:0]));
      blk1 = req_i[0] & req_i[1] & (dir_i[0] == dir_i[1]);
      for (int i = 0; i < 2; i++) begin
        if (req_i[i] && !(i == 1 && blk1)) begin
          int d;
          d = int'(dir_i[i]);
          check($sformatf("R5 vec%0d addr p%0d", v, i), 32'(dn_addr_o[d*AW +: AW]), 32'(addr_i[i*AW +: AW]));
          check($sformatf("R5 vec%0d wdata p%0d", v, i), 32'(dn_wdata_o[d*DW +: DW]), 32'(wdata_i[i*DW +: DW]));
          check($sformatf("R5 vec%0d we p%0d", v, i), 32'(dn_we_o[d]), 32'(we_i[i]));
          check($sformatf("R6 vec%0d rdata p%0d", v, i), 32'(rdata_o[i*DW +: DW]), 32'(dn_rdata_i[d*DW +: DW]));
        end
      end
    end

    // R9: hold a cross connection, change only downstream read data
    @(negedge clk);
    req_i = 2'b11; dir_i = 2'b01; dn_busy_i = 2'b00;
    dn_rdata_i = {12'h111, 12'h222};
    #1;
    check("R9 p0 first", 32'(rdata_o[DW-1:0]),    32'h111);
    check("R9 p1 first", 32'(rdata_o[2*DW-1:DW]), 32'h222);
    @(negedge clk);
    dn_rdata_i = {12'h5A5, 12'h3C3};
    #1;
    check("R9 p0 held", 32'(rdata_o[DW-1:0]),    32'h5A5);
    check("R9 p1 held", 32'(rdata_o[2*DW-1:DW]), 32'h3C3);

    // R8 corner: idle port with both downstream busy
    @(negedge clk);
    req_i = 2'b10; dir_i = 2'b10; dn_busy_i = 2'b11;
    #1;
    check("R8 idle port0 busy", 32'(busy_o[0]), 32'h0);

    // R1 back to idle
    @(negedge clk);
    req_i = 2'b00;
    #1;
    check("R1 return idle", 32'({dn_req_o, busy_o}), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule